// File: doc/BRIEF.md
# Dual Accelerometer Voter with Reference Arbitration

This block merges two redundant load-factor sensors into one trusted value. A sample arrives with a strobe. The block compares the two accelerometer readings. While they stay within a threshold of each other, it publishes their half-sum. When the gap persists beyond the threshold, a third, independent reference reading decides which sensor is at fault. That sensor is flagged, and the other one is forwarded directly.

Once only one sensor is left, that sensor is checked against the reference under the same threshold and persistence rule. If the remaining sensor is also condemned, the output strobe stops. Fault flags stay set until a synchronous clear. All values are 16-bit signed two's complement. The result appears one clock after the sample strobe.

Top module: `acc_voter`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `nz_o` is 0 and `nz_valid_o`, `fault_a_o` and `fault_b_o` are low.
- R2: With both sensors healthy, each accepted sample gives `nz_valid_o` high one cycle later. In that cycle `nz_o` is floor((a+b)/2), computed on a 17-bit sum with an arithmetic shift. For example, (3,-2) gives 0 and (-3,0) gives -2.
- R3: Two values miscompare only when their absolute difference is strictly greater than `thresh_i`, an unsigned number. A difference equal to `thresh_i` counts as agreement.
- R4: A fault latches on the PERSIST-th consecutive accepted miscomparing sample (PERSIST defaults to 3). An accepted agreeing sample restarts the count. Cycles without `smp_valid_i` neither count nor restart it. The count restarts after every latch.
- R5: When both sensors are healthy, the sensor blamed is the one whose absolute distance from `ref_i` is larger. On a tie, sensor A is blamed.
- R6: Before a fault is confirmed, a miscomparing sample still outputs the half-sum.
- R7: After exactly one fault, `nz_o` is the surviving sensor's raw value. This starts with the sample on which the fault latches.
- R8: A lone survivor is compared with `ref_i` using the R3 and R4 rules. When both flags are set, `nz_valid_o` stays low.
- R9: The flags are sticky. A cycle with `clear_i` high clears both flags and the persistence count, and discards any sample in that cycle, so `nz_valid_o` is low next cycle.
- R10: `nz_o` holds its last published value in every cycle where `nz_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample strobe |
| acc_a_i | input | 16 | Sensor A load factor, signed |
| acc_b_i | input | 16 | Sensor B load factor, signed |
| ref_i | input | 16 | Independent reference load factor, signed |
| thresh_i | input | 16 | Disagreement threshold, unsigned |
| clear_i | input | 1 | Clears fault flags and persistence count |
| nz_o | output | 16 | Voted load factor, signed |
| nz_valid_o | output | 1 | Voted value valid, one cycle after sample |
| fault_a_o | output | 1 | Sensor A condemned |
| fault_b_o | output | 1 | Sensor B condemned |

## Verification
The bench checks the threshold boundary at exactly equal and one above. A `>=` comparison would latch a fault where none is due.

It breaks a run of miscompares with an agreeing sample, and separately with idle cycles. A counter that ignores agreeing samples would latch early. A counter reset by idle cycles would never latch.

It drives a distance tie against the reference, where blaming B is an error. It also checks the output on the latching sample itself, where a design that still averaged would be off by half the gap. Finally, it condemns both sensors and clears them with a simultaneous sample, which must be dropped. Random traffic with occasional sensor offsets and clears is compared against a bench model throughout.

// File: rtl/acc_mon_pkg.sv
package acc_mon_pkg;

    typedef enum logic [1:0] {
        HS_BOTH   = 2'd0,
        HS_A_ONLY = 2'd1,
        HS_B_ONLY = 2'd2,
        HS_NONE   = 2'd3
    } health_e;

    function automatic health_e health_of(input logic fa, input logic fb);
        if (fa && fb)  return HS_NONE;
        if (fa)        return HS_B_ONLY;
        if (fb)        return HS_A_ONLY;
        return HS_BOTH;
    endfunction

endpackage

// File: rtl/acc_compare.sv
module acc_compare
    import acc_mon_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    input  logic [W-1:0] thresh,
    input  health_e      hs,
    output logic         miscmp,
    output logic         blame_a
);
    localparam int DW = W + 1;

    function automatic logic [DW-1:0] absdiff(input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [DW-1:0] xe;
        logic signed [DW-1:0] ye;
        logic signed [DW-1:0] d;
        xe = {x[W-1], x};
        ye = {y[W-1], y};
        d  = xe - ye;
        return d[DW-1] ? DW'(-d) : DW'(d);
    endfunction

    logic [DW-1:0] d_ab, d_ar, d_br, th_e;

    always_comb begin
        d_ab = absdiff(a, b);
        d_ar = absdiff(a, r);
        d_br = absdiff(b, r);
        th_e = {1'b0, thresh};
        miscmp  = 1'b0;
        blame_a = 1'b0;
        case (hs)
            HS_BOTH: begin
                miscmp  = d_ab > th_e;
                blame_a = d_ar >= d_br;
            end
            HS_A_ONLY: begin
                miscmp  = d_ar > th_e;
                blame_a = 1'b1;
            end
            HS_B_ONLY: begin
                miscmp  = d_br > th_e;
                blame_a = 1'b0;
            end
            default: begin
                miscmp  = 1'b0;
                blame_a = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_persist.sv
module acc_persist #(
    parameter int PERSIST = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic miscmp,
    output logic fire
);
    localparam int CW = (PERSIST < 2) ? 1 : $clog2(PERSIST + 1);

    logic [CW-1:0] cnt_q;

    assign fire = step && miscmp && (cnt_q == CW'(PERSIST - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            if (!miscmp || fire) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/acc_select.sv
module acc_select
    import acc_mon_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  health_e      hs,
    output logic [W-1:0] value,
    output logic         ok
);
    logic [W:0] sum;

    always_comb begin
        sum = {a[W-1], a} + {b[W-1], b};
        value = '0;
        ok    = 1'b1;
        case (hs)
            HS_BOTH:   value = sum[W:1];
            HS_A_ONLY: value = a;
            HS_B_ONLY: value = b;
            default: begin
                value = '0;
                ok    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_voter.sv
module acc_voter
    import acc_mon_pkg::*;
#(
    parameter int W       = 16,
    parameter int PERSIST = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_valid_i,
    input  logic [W-1:0] acc_a_i,
    input  logic [W-1:0] acc_b_i,
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] thresh_i,
    input  logic         clear_i,
    output logic [W-1:0] nz_o,
    output logic         nz_valid_o,
    output logic         fault_a_o,
    output logic         fault_b_o
);
    logic         fa_q, fb_q;
    logic         step, miscmp, blame_a, fire;
    logic         fa_n, fb_n, sel_ok;
    logic [W-1:0] sel_val;
    health_e      hs_now, hs_next;

    assign step    = smp_valid_i && !clear_i;
    assign hs_now  = health_of(fa_q, fb_q);
    assign fa_n    = fa_q || (fire && blame_a);
    assign fb_n    = fb_q || (fire && !blame_a);
    assign hs_next = health_of(fa_n, fb_n);

    acc_compare #(.W(W)) u_cmp (
        .a(acc_a_i), .b(acc_b_i), .r(ref_i), .thresh(thresh_i),
        .hs(hs_now), .miscmp(miscmp), .blame_a(blame_a)
    );

    acc_persist #(.PERSIST(PERSIST)) u_per (
        .clk(clk), .rst(rst), .clear(clear_i), .step(step),
        .miscmp(miscmp), .fire(fire)
    );

    acc_select #(.W(W)) u_sel (
        .a(acc_a_i), .b(acc_b_i), .hs(hs_next),
        .value(sel_val), .ok(sel_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q       <= 1'b0;
            fb_q       <= 1'b0;
            nz_o       <= '0;
            nz_valid_o <= 1'b0;
        end else if (clear_i) begin
            fa_q       <= 1'b0;
            fb_q       <= 1'b0;
            nz_valid_o <= 1'b0;
        end else begin
            nz_valid_o <= 1'b0;
            if (step) begin
                fa_q <= fa_n;
                fb_q <= fb_n;
                if (sel_ok) begin
                    nz_o       <= sel_val;
                    nz_valid_o <= 1'b1;
                end
            end
        end
    end

    assign fault_a_o = fa_q;
    assign fault_b_o = fb_q;

endmodule

// File: rtl/acc_voter_chk.sv
module acc_voter_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         smp_valid_i,
    input logic         clear_i,
    input logic [W-1:0] acc_a_i,
    input logic [W-1:0] acc_b_i,
    input logic [W-1:0] nz_o,
    input logic         nz_valid_o,
    input logic         fault_a_o,
    input logic         fault_b_o
);
    logic [W:0] hsum;
    assign hsum = {acc_a_i[W-1], acc_a_i} + {acc_b_i[W-1], acc_b_i};

    // R2
    avg_out_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(smp_valid_i && !clear_i) && !fault_a_o && !fault_b_o)
        |-> (nz_valid_o && nz_o == $past(hsum[W:1])));

    // R7
    survivor_b_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(smp_valid_i && !clear_i) && fault_a_o && !fault_b_o)
        |-> (nz_valid_o && nz_o == $past(acc_b_i)));

    // R8
    both_dead_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_a_o && fault_b_o) |-> !nz_valid_o);

    // R9
    sticky_a_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_a_o) |-> $past(clear_i));

    // R9
    sticky_b_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_b_o) |-> $past(clear_i));

    // R9
    clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clear_i) |-> (!fault_a_o && !fault_b_o && !nz_valid_o));

    // R5
    single_blame_chk: assert property (@(posedge clk) disable iff (rst)
        !($rose(fault_a_o) && $rose(fault_b_o)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !nz_valid_o |-> $stable(nz_o));

endmodule

bind acc_voter acc_voter_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i), .clear_i(clear_i),
    .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .nz_o(nz_o),
    .nz_valid_o(nz_valid_o), .fault_a_o(fault_a_o), .fault_b_o(fault_b_o)
);

// File: tb/sim_acc_voter.sv
`timescale 1ns/1ps
module sim_acc_voter;
    localparam int P = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_v = 1'b0, clr = 1'b0;
    logic signed [15:0] a_in = '0, b_in = '0, r_in = '0;
    logic [15:0] th = 16'd100;
    logic [15:0] nz;
    logic nz_v, fa, fb;

    int checks = 0, errors = 0;
    bit done = 0;

    int m_fa = 0, m_fb = 0, m_cnt = 0, m_out = 0, m_v = 0;

    always #10 clk = ~clk;

    acc_voter u0 (
        .clk(clk), .rst(rst), .smp_valid_i(smp_v), .acc_a_i(a_in), .acc_b_i(b_in),
        .ref_i(r_in), .thresh_i(th), .clear_i(clr), .nz_o(nz), .nz_valid_o(nz_v),
        .fault_a_o(fa), .fault_b_o(fb)
    );

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int half(input int x, input int y);
        return (x + y) >>> 1;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_step(input int a, input int b, input int r, input int t,
                              input bit v, input bit c);
        int mis, blame_a;
        if (c) begin
            m_fa = 0; m_fb = 0; m_cnt = 0; m_v = 0;
        end else if (v) begin
            mis = 0; blame_a = 0;
            if (!m_fa && !m_fb) begin
                mis = iabs(a - b) > t;
                blame_a = iabs(a - r) >= iabs(b - r);
            end else if (m_fa && !m_fb) begin
                mis = iabs(b - r) > t; blame_a = 0;
            end else if (!m_fa && m_fb) begin
                mis = iabs(a - r) > t; blame_a = 1;
            end
            if (mis) begin
                m_cnt++;
                if (m_cnt == P) begin
                    m_cnt = 0;
                    if (blame_a) m_fa = 1; else m_fb = 1;
                end
            end else m_cnt = 0;
            m_v = 1;
            if (!m_fa && !m_fb)      m_out = half(a, b);
            else if (m_fa && !m_fb)  m_out = b;
            else if (!m_fa && m_fb)  m_out = a;
            else                     m_v = 0;
        end else m_v = 0;
    endtask

    task automatic drive(input int a, input int b, input int r, input bit v,
                         input bit c, input string tag);
        @(negedge clk);
        a_in = 16'(a); b_in = 16'(b); r_in = 16'(r); smp_v = v; clr = c;
        @(posedge clk);
        #1;
        model_step(a, b, r, int'(th), v, c);
        chk({tag, " valid"}, int'(nz_v), m_v);
        chk({tag, " fault_a"}, int'(fa), m_fa);
        chk({tag, " fault_b"}, int'(fb), m_fb);
        chk({tag, " value"}, int'($signed(nz)), m_out);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", int'(nz_v), 0);
        chk("R1 reset flags", int'(fa) + int'(fb), 0);
        chk("R1 reset value", int'(nz), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 post-reset valid", int'(nz_v), 0);
        chk("R1 post-reset value", int'(nz), 0);

        // R2 averages and rounding
        drive(1000, 1002, 1001, 1, 0, "R2 avg");
        drive(3, -2, 0, 1, 0, "R2 round pos");
        chk("R2 floor 3,-2", int'($signed(nz)), 0);
        drive(-3, 0, 0, 1, 0, "R2 round neg");
        chk("R2 floor -3,0", int'($signed(nz)), -2);
        drive(32767, 32767, 32767, 1, 0, "R2 max");
        drive(-32768, -32768, -32768, 1, 0, "R2 min");

        // R3 boundary: equal to threshold is agreement
        for (int i = 0; i < 4; i++) drive(0, 100, 0, 1, 0, "R3 equal");
        chk("R3 no fault at equal", int'(fb), 0);
        for (int i = 0; i < 3; i++) drive(0, 101, 0, 1, 0, "R3 above");
        chk("R3 fault above", int'(fb), 1);
        drive(0, 0, 0, 0, 1, "R9 clear");

        // R4 agreeing sample restarts; idle cycles do not
        drive(0, 500, 0, 1, 0, "R4 mis1");
        drive(0, 500, 0, 1, 0, "R4 mis2");
        drive(0, 10, 0, 1, 0, "R4 agree");
        drive(0, 500, 0, 1, 0, "R4 mis1b");
        drive(0, 500, 0, 1, 0, "R4 mis2b");
        chk("R4 no early fault", int'(fb), 0);
        // R6 unconfirmed miscompare still averaged
        chk("R6 avg during miscompare", int'($signed(nz)), 250);
        drive(0, 10, 0, 1, 0, "R4 agree2");
        drive(0, 500, 0, 1, 0, "R4 gap mis1");
        drive(7, 7, 7, 0, 0, "R4 idle");
        drive(0, 500, 0, 1, 0, "R4 gap mis2");
        drive(7, 7, 7, 0, 0, "R10 idle hold");
        chk("R10 held value", int'($signed(nz)), 250);
        drive(0, 500, 0, 1, 0, "R4 gap mis3");
        chk("R4 fault after idle gaps", int'(fb), 1);
        chk("R7 survivor on latch", int'($signed(nz)), 0);
        drive(0, 0, 0, 0, 1, "R9 clear2");

        // R5 tie blames A, R7 survivor B, R8 both condemned
        drive(100, -100, 0, 1, 0, "R5 tie1");
        drive(100, -100, 0, 1, 0, "R5 tie2");
        drive(100, -100, 0, 1, 0, "R5 tie3");
        chk("R5 tie blames A", int'(fa), 1);
        chk("R5 tie spares B", int'(fb), 0);
        chk("R7 survivor raw", int'($signed(nz)), -100);
        drive(900, -50, -20, 1, 0, "R7 pass");
        chk("R7 pass b", int'($signed(nz)), -50);
        for (int i = 0; i < 3; i++) drive(0, 400, 0, 1, 0, "R8 survivor bad");
        chk("R8 both flags", int'(fa) + int'(fb), 2);
        chk("R8 valid low", int'(nz_v), 0);
        drive(5, 5, 5, 1, 0, "R8 still low");
        drive(5, 5, 5, 1, 1, "R9 clear with sample");
        chk("R9 sample dropped", int'(nz_v), 0);
        drive(5, 5, 5, 1, 0, "R9 healthy again");

        // random traffic
        for (int blk = 0; blk < 6; blk++) begin
            th = 16'(20 + $urandom_range(0, 300));
            for (int i = 0; i < 500; i++) begin
                int base, na, nb, rr;
                base = $urandom_range(0, 8000) - 4000;
                na = base + $urandom_range(0, 40) - 20;
                nb = base + $urandom_range(0, 40) - 20;
                rr = base + $urandom_range(0, 20) - 10;
                if ($urandom_range(0, 9) == 0) na = na + $urandom_range(0, 2000) - 1000;
                if ($urandom_range(0, 9) == 0) nb = nb + $urandom_range(0, 2000) - 1000;
                drive(na, nb, rr, $urandom_range(0, 9) < 8,
                      $urandom_range(0, 99) == 0, "R2-R8 random");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial void'($urandom(32'd1234));

endmodule